// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the multicycle control unit a 16-bit processor hands control to when it takes an interrupt or an exception, and when it executes the return-from-interrupt instruction. It owns the processor status word, the working stack pointer R6 and the two parked stack pointers (one for user code, one for supervisor code). On entry it swaps to the supervisor stack if needed, pushes the status word and the return PC, raises the status word to supervisor mode at the serviced level with condition codes cleared, and then fetches the handler address from the vector table. On return it pops the PC and the status word and, when the restored status word says user mode, swaps back to the user stack.

Every memory access is a single request held steady until the memory acknowledges it. The surrounding core starts a sequence with a one-cycle pulse while the sequencer is idle, and waits for the one-cycle completion pulse before fetching at the new PC. A return attempted from user mode never pops anything; it is turned into a privilege exception entered at the current level.

Top module: `intr_seq`

## Requirements
- R1: After reset the status word reads 0x8002 (user mode, level 0, condition codes 010), R6 reads 0x4000, and busy, done and mem_req are all low.
- R2: An entry started in user mode parks R6 as the user stack pointer, loads R6 from the parked supervisor pointer (0x3000 after reset), then writes the old status word at R6-1 and the return PC at R6-2, leaving R6 two below the supervisor pointer.
- R3: An entry started in supervisor mode keeps R6 and pushes its frame directly below the existing one, so nested entries stack up.
- R4: At the end of an entry the status word has bit 15 (privilege) at 0, bits 10:8 (level) equal to the requested level, and bits 2:0 (condition codes) at 000.
- R5: The handler address is read from address {0x01, vector}; pc_out carries that word and done pulses for one cycle in the cycle after the final acknowledge.
- R6: A return in supervisor mode reads the PC at R6, then the status word at R6+1, and leaves R6 two higher than before.
- R7: When the restored status word has bit 15 set, R6 is reloaded with the parked user stack pointer, and the supervisor pointer in use is parked for the next entry.
- R8: A return requested in user mode performs no reads of the stack; it enters through vector 0x00 at the current level, pushing the status word and pc_in like any entry.
- R9: Start requests while busy are ignored, and when entry and return are requested in the same idle cycle the entry is taken.
- R10: Each access keeps mem_req, mem_we, mem_addr and mem_wdata steady until mem_ack, and R6 moves only on an acknowledged access.
- R11: While idle, cc_we loads cc_in into status bits 2:0 and leaves the other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_entry | input | 1 | One-cycle request to take an interrupt or exception |
| entry_vec | input | 8 | Vector of the request being taken |
| entry_lvl | input | 3 | Priority level of the request being taken |
| start_rti | input | 1 | One-cycle request to execute the return instruction |
| pc_in | input | 16 | PC to save on entry |
| cc_we | input | 1 | Load condition codes while idle |
| cc_in | input | 3 | Condition code value to load |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes in this cycle |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: sequence finished, pc_out valid |
| pc_out | output | 16 | PC to fetch from next |
| psr_out | output | 16 | Current status word |
| r6_out | output | 16 | Current stack pointer R6 |

## Verification
A start pulse is taken at the clock edge where it is high, so the stack swap of R2 and the first request are visible one cycle later, and each access completes at the edge on which mem_ack is high. The completion pulse, the new PC, the final status word and R6 all appear one cycle after the final acknowledge, so the bench polls done at falling edges and reads every result in that same sample. Pushed words are checked in the bench's memory model after done, and the memory model is run with several acknowledge latencies so that held requests and the stack pointer in mid-access are sampled while mem_ack is still low.

// File: rtl/isq_pkg.sv
package isq_pkg;

    localparam int DATA_W = 16;
    localparam int VEC_W  = 8;
    localparam int LVL_W  = 3;
    localparam int CC_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PSR,
        ST_PUSH_PC,
        ST_VEC,
        ST_POP_PC,
        ST_POP_PSR
    } isq_st_t;

    // Status word: bit 15 privilege (1 = user), 10:8 level, 2:0 condition codes
    typedef struct packed {
        logic             user;
        logic [3:0]       rsv_hi;
        logic [LVL_W-1:0] lvl;
        logic [4:0]       rsv_lo;
        logic [CC_W-1:0]  cc;
    } psr_t;

    function automatic logic is_push(input isq_st_t s);
        return (s == ST_PUSH_PSR) || (s == ST_PUSH_PC);
    endfunction

    function automatic logic [DATA_W-1:0] table_addr(input logic [VEC_W-1:0] page,
                                                     input logic [VEC_W-1:0] v);
        return {page, v};
    endfunction

endpackage

// File: rtl/isq_fsm.sv
module isq_fsm
    import isq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_entry,
    input  logic    start_rti,
    input  logic    user_mode,
    input  logic    mem_ack,
    output isq_st_t st,
    output logic    acc_entry,
    output logic    acc_rti,
    output logic    trap
);
    isq_st_t st_nx;
    logic    idle;

    assign idle      = (st == ST_IDLE);
    assign trap      = idle && !start_entry && start_rti && user_mode;
    assign acc_entry = idle && (start_entry || trap);
    assign acc_rti   = idle && !start_entry && start_rti && !user_mode;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (acc_entry)    st_nx = ST_PUSH_PSR;
                else if (acc_rti) st_nx = ST_POP_PC;
            end
            ST_PUSH_PSR: if (mem_ack) st_nx = ST_PUSH_PC;
            ST_PUSH_PC:  if (mem_ack) st_nx = ST_VEC;
            ST_VEC:      if (mem_ack) st_nx = ST_IDLE;
            ST_POP_PC:   if (mem_ack) st_nx = ST_POP_PSR;
            ST_POP_PSR:  if (mem_ack) st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end
endmodule

// File: rtl/isq_memif.sv
module isq_memif
    import isq_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_PAGE = 8'h01
)(
    input  isq_st_t           st,
    input  logic [DATA_W-1:0] r6,
    input  psr_t              psr,
    input  logic [DATA_W-1:0] saved_pc,
    input  logic [VEC_W-1:0]  vec,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    always_comb begin
        mem_req   = (st != ST_IDLE);
        mem_we    = is_push(st);
        mem_addr  = r6;
        mem_wdata = '0;
        unique case (st)
            ST_PUSH_PSR: begin
                mem_addr  = r6 - DATA_W'(1);
                mem_wdata = psr;
            end
            ST_PUSH_PC: begin
                mem_addr  = r6 - DATA_W'(1);
                mem_wdata = saved_pc;
            end
            ST_VEC:  mem_addr = table_addr(VEC_PAGE, vec);
            default: mem_addr = r6;
        endcase
    end
endmodule

// File: rtl/isq_state.sv
module isq_state
    import isq_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_PSR = 16'h8002,
    parameter logic [DATA_W-1:0] SSP_INIT  = 16'h3000,
    parameter logic [DATA_W-1:0] USP_INIT  = 16'h4000,
    parameter logic [VEC_W-1:0]  PRIV_VEC  = 8'h00
)(
    input  logic              clk,
    input  logic              rst,
    input  isq_st_t           st,
    input  logic              acc_entry,
    input  logic              trap,
    input  logic [VEC_W-1:0]  entry_vec,
    input  logic [LVL_W-1:0]  entry_lvl,
    input  logic [DATA_W-1:0] pc_in,
    input  logic              cc_we,
    input  logic [CC_W-1:0]   cc_in,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output psr_t              psr,
    output logic [DATA_W-1:0] r6,
    output logic [DATA_W-1:0] saved_pc,
    output logic [VEC_W-1:0]  vec,
    output logic [DATA_W-1:0] pc_out,
    output logic              done
);
    logic [DATA_W-1:0] usp_park;
    logic [DATA_W-1:0] ssp_park;
    logic [LVL_W-1:0]  tgt_lvl;
    psr_t              rd_psr;

    assign rd_psr = psr_t'(mem_rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            psr      <= psr_t'(RESET_PSR);
            r6       <= USP_INIT;
            usp_park <= USP_INIT;
            ssp_park <= SSP_INIT;
            saved_pc <= '0;
            vec      <= '0;
            tgt_lvl  <= '0;
            pc_out   <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (acc_entry) begin
                        saved_pc <= pc_in;
                        vec      <= trap ? PRIV_VEC : entry_vec;
                        tgt_lvl  <= trap ? psr.lvl : entry_lvl;
                        if (psr.user) begin
                            usp_park <= r6;
                            r6       <= ssp_park;
                        end
                    end else if (cc_we) begin
                        psr.cc <= cc_in;
                    end
                end
                ST_PUSH_PSR: if (mem_ack) r6 <= r6 - DATA_W'(1);
                ST_PUSH_PC: if (mem_ack) begin
                    r6       <= r6 - DATA_W'(1);
                    psr.user <= 1'b0;
                    psr.lvl  <= tgt_lvl;
                    psr.cc   <= '0;
                end
                ST_VEC: if (mem_ack) begin
                    pc_out <= mem_rdata;
                    done   <= 1'b1;
                end
                ST_POP_PC: if (mem_ack) begin
                    pc_out <= mem_rdata;
                    r6     <= r6 + DATA_W'(1);
                end
                ST_POP_PSR: if (mem_ack) begin
                    psr  <= rd_psr;
                    done <= 1'b1;
                    if (rd_psr.user) begin
                        ssp_park <= r6 + DATA_W'(1);
                        r6       <= usp_park;
                    end else begin
                        r6 <= r6 + DATA_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import isq_pkg::*;
#(
    parameter logic [15:0] RESET_PSR = 16'h8002,
    parameter logic [15:0] SSP_INIT  = 16'h3000,
    parameter logic [15:0] USP_INIT  = 16'h4000,
    parameter logic [7:0]  PRIV_VEC  = 8'h00,
    parameter logic [7:0]  VEC_PAGE  = 8'h01
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_entry,
    input  logic [7:0]  entry_vec,
    input  logic [2:0]  entry_lvl,
    input  logic        start_rti,
    input  logic [15:0] pc_in,
    input  logic        cc_we,
    input  logic [2:0]  cc_in,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    input  logic        mem_ack,
    output logic        busy,
    output logic        done,
    output logic [15:0] pc_out,
    output logic [15:0] psr_out,
    output logic [15:0] r6_out
);
    isq_st_t           st;
    logic              acc_entry, acc_rti, trap;
    psr_t              psr;
    logic [DATA_W-1:0] r6, saved_pc;
    logic [VEC_W-1:0]  vec;

    isq_fsm u_fsm (
        .clk(clk), .rst(rst),
        .start_entry(start_entry), .start_rti(start_rti),
        .user_mode(psr.user), .mem_ack(mem_ack),
        .st(st), .acc_entry(acc_entry), .acc_rti(acc_rti), .trap(trap)
    );

    isq_state #(
        .RESET_PSR(RESET_PSR), .SSP_INIT(SSP_INIT),
        .USP_INIT(USP_INIT), .PRIV_VEC(PRIV_VEC)
    ) u_state (
        .clk(clk), .rst(rst), .st(st),
        .acc_entry(acc_entry), .trap(trap),
        .entry_vec(entry_vec), .entry_lvl(entry_lvl), .pc_in(pc_in),
        .cc_we(cc_we), .cc_in(cc_in),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .psr(psr), .r6(r6), .saved_pc(saved_pc), .vec(vec),
        .pc_out(pc_out), .done(done)
    );

    isq_memif #(.VEC_PAGE(VEC_PAGE)) u_memif (
        .st(st), .r6(r6), .psr(psr), .saved_pc(saved_pc), .vec(vec),
        .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    assign busy    = (st != ST_IDLE);
    assign psr_out = psr;
    assign r6_out  = r6;
endmodule

// File: rtl/isq_chk.sv
module isq_chk
    import isq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input isq_st_t     st,
    input logic        busy,
    input logic        done,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic        mem_ack,
    input logic [15:0] psr_out,
    input logic [15:0] r6_out
);
    // R1
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R10
    a_r10_hold_req: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

    // R10
    a_r10_sp_on_ack: assert property (@(posedge clk) disable iff (rst)
        busy && !mem_ack |=> $stable(r6_out));

    // R2
    a_r2_push_below_sp: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_addr == r6_out - 16'd1);

    // R4
    a_r4_entry_psr: assert property (@(posedge clk) disable iff (rst)
        done && $past(st) == ST_VEC |-> !psr_out[15] && psr_out[2:0] == 3'b000);

    // R5
    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind intr_seq isq_chk u_chk (
    .clk(clk), .rst(rst), .st(st), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .psr_out(psr_out), .r6_out(r6_out)
);

// File: tb/tb_intr_seq.sv
`timescale 1ns/1ps
module tb_intr_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_entry = 1'b0;
    logic [7:0]  entry_vec = '0;
    logic [2:0]  entry_lvl = '0;
    logic        start_rti = 1'b0;
    logic [15:0] pc_in = '0;
    logic        cc_we = 1'b0;
    logic [2:0]  cc_in = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        busy, done;
    logic [15:0] pc_out, psr_out, r6_out;

    int n_tests = 0;
    int n_fail  = 0;
    int lat     = 0;
    logic [15:0] mem [logic [15:0]];

    always #10 clk = ~clk;

    intr_seq dut (
        .clk(clk), .rst(rst), .start_entry(start_entry), .entry_vec(entry_vec),
        .entry_lvl(entry_lvl), .start_rti(start_rti), .pc_in(pc_in),
        .cc_we(cc_we), .cc_in(cc_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .done(done), .pc_out(pc_out),
        .psr_out(psr_out), .r6_out(r6_out)
    );

    function automatic logic [15:0] rd(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    // memory model: acknowledges after lat idle cycles
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (cnt < lat) cnt++;
                else begin
                    cnt = 0;
                    mem_ack = 1'b1;
                    mem_rdata = rd(mem_addr);
                    if (mem_we) mem[mem_addr] = mem_wdata;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_entry(input logic [7:0] v, input logic [2:0] l, input logic [15:0] pc);
        @(negedge clk);
        entry_vec = v; entry_lvl = l; pc_in = pc; start_entry = 1'b1;
        @(negedge clk);
        start_entry = 1'b0;
    endtask

    task automatic pulse_rti(input logic [15:0] pc);
        @(negedge clk);
        pc_in = pc; start_rti = 1'b1;
        @(negedge clk);
        start_rti = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int seen = 0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(req, 16'(seen), 16'd1);
    endtask

    task automatic t_reset;
        chk("R1 psr", psr_out, 16'h8002);
        chk("R1 r6", r6_out, 16'h4000);
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 req", {15'd0, mem_req}, 16'd0);
        chk("R1 done", {15'd0, done}, 16'd0);
    endtask

    task automatic t_cc_load;
        @(negedge clk);
        cc_in = 3'b100; cc_we = 1'b1;
        @(negedge clk);
        cc_we = 1'b0;
        chk("R11 cc load", psr_out, 16'h8004);
    endtask

    task automatic t_entry_user;
        lat = 3;
        pulse_entry(8'h80, 3'd4, 16'h3007);
        // swapped to supervisor stack, first push still waiting
        chk("R10 r6 before ack", r6_out, 16'h3000);
        chk("R2 push addr", mem_addr, 16'h2FFF);
        chk("R10 req held", {15'd0, mem_req & mem_we}, 16'd1);
        wait_done("R5 done entry");
        chk("R2 psr pushed", rd(16'h2FFF), 16'h8004);
        chk("R2 pc pushed", rd(16'h2FFE), 16'h3007);
        chk("R2 r6 after", r6_out, 16'h2FFE);
        chk("R4 psr", psr_out, 16'h0400);
        chk("R5 handler pc", pc_out, 16'h6200);
        @(negedge clk);
        chk("R5 done one cycle", {15'd0, done}, 16'd0);
    endtask

    task automatic t_entry_nested;
        lat = 0;
        pulse_entry(8'h81, 3'd6, 16'h6203);
        wait_done("R3 done nested");
        chk("R3 psr pushed", rd(16'h2FFD), 16'h0400);
        chk("R3 pc pushed", rd(16'h2FFC), 16'h6203);
        chk("R3 r6", r6_out, 16'h2FFC);
        chk("R4 psr nested", psr_out, 16'h0600);
        chk("R5 pc nested", pc_out, 16'h6300);
    endtask

    task automatic t_rti_super;
        lat = 2;
        pulse_rti(16'h6315);
        // entry request while busy must be ignored
        @(negedge clk);
        entry_vec = 8'h80; entry_lvl = 3'd7; start_entry = 1'b1;
        @(negedge clk);
        start_entry = 1'b0;
        wait_done("R6 done rti");
        chk("R6 pc", pc_out, 16'h6203);
        chk("R6 psr", psr_out, 16'h0400);
        chk("R6 r6", r6_out, 16'h2FFE);
        repeat (3) @(negedge clk);
        chk("R9 busy ignored", {15'd0, busy}, 16'd0);
        chk("R9 r6 ignored", r6_out, 16'h2FFE);
    endtask

    task automatic t_rti_user;
        lat = 1;
        pulse_rti(16'h6210);
        wait_done("R7 done rti");
        chk("R7 pc", pc_out, 16'h3007);
        chk("R7 psr", psr_out, 16'h8004);
        chk("R7 r6 user", r6_out, 16'h4000);
    endtask

    task automatic t_rti_trap;
        lat = 0;
        mem[16'h4000] = 16'hDEAD;
        pulse_rti(16'h3100);
        wait_done("R8 done trap");
        chk("R8 psr pushed", rd(16'h2FFF), 16'h8004);
        chk("R8 pc pushed", rd(16'h2FFE), 16'h3100);
        chk("R8 handler pc", pc_out, 16'h1000);
        chk("R8 psr", psr_out, 16'h0000);
        chk("R8 r6", r6_out, 16'h2FFE);
    endtask

    task automatic t_both;
        lat = 1;
        @(negedge clk);
        entry_vec = 8'h80; entry_lvl = 3'd2; pc_in = 16'h1005;
        start_entry = 1'b1; start_rti = 1'b1;
        @(negedge clk);
        start_entry = 1'b0; start_rti = 1'b0;
        wait_done("R9 done both");
        chk("R9 pc pushed", rd(16'h2FFC), 16'h1005);
        chk("R9 psr pushed", rd(16'h2FFD), 16'h0000);
        chk("R9 r6", r6_out, 16'h2FFC);
        chk("R9 psr", psr_out, 16'h0200);
        chk("R9 pc", pc_out, 16'h6200);
    endtask

    initial begin
        #(20ns * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        mem[16'h0180] = 16'h6200;
        mem[16'h0181] = 16'h6300;
        mem[16'h0100] = 16'h1000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cc_load();
        t_entry_user();
        t_entry_nested();
        t_rti_super();
        t_rti_user();
        t_rti_trap();
        t_both();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule